// File: doc/BRIEF.md
# Lockable Watchdog Timer

This block is the watchdog for a small 8-bit controller core. Software reaches it through a single write-only special function register. After a system reset the watchdog is idle. It starts only when software writes a fixed two-byte key to that register. Writing the same key again while it runs restarts the count, which is how software services it. Once started, no register write can stop it. Only a qualified external reset or its own timeout puts it back to idle.

The count advances on a one-clock machine-cycle enable. The core supplies this enable, normally once every twelve oscillator clocks. When the 14-bit count wraps, the block does three things:

- It raises an internal reset request for one machine cycle.
- It drives the reset pin high for a fixed number of oscillator clocks, unless a disable input is high.
- It returns itself to idle.

The reset pin is also watched as an input. It counts as an external reset only after it has been high for two consecutive machine cycles.

Top module: `wdt_guard`

## Requirements
- R1: While `rst` is high and after it is released, the watchdog is idle and both `wdt_rst_o` and `rst_pin_drive_o` are low.
- R2: A write of 8'h1E followed by a write of 8'hE1 to SFR address 8'hA6 arms the watchdog. Writes are taken at rising edges where `sfr_we` is high, and idle cycles may lie between the two writes. When `mc_en` is high on every clock, `wdt_rst_o` first reads high exactly 16384 clocks after the edge that took the 8'hE1 write.
- R3: Repeating the 1EH/E1H pair while armed restarts the count. The next request comes 16384 machine cycles after the second write of the repeated pair.
- R4: The following writes neither arm nor service the watchdog: a lone 8'hE1, a 8'h1E followed by any other byte before the 8'hE1, and writes to any address other than 8'hA6.
- R5: Once armed, no SFR write stops the watchdog or delays its timeout unless the write completes the key pair.
- R6: `wdt_rst_o` stays high for exactly one machine cycle. It falls at the next clock edge where `mc_en` is high.
- R7: On timeout, `rst_pin_drive_o` rises in the same cycle as `wdt_rst_o` and stays high for 98 clock cycles.
- R8: If `rto_dis_i` is high at the timeout edge, `rst_pin_drive_o` stays low, but `wdt_rst_o` is still issued.
- R9: `rst_pin_i` held high for two consecutive machine cycles returns the watchdog to idle, so no timeout follows. A high lasting one machine cycle has no effect.
- R10: After a timeout the watchdog is idle and produces no further request until it is armed again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high system reset |
| mc_en | input | 1 | One-clock pulse per machine cycle |
| sfr_we | input | 1 | SFR write strobe |
| sfr_addr | input | 8 | SFR write address |
| sfr_wdata | input | 8 | SFR write data |
| rst_pin_i | input | 1 | Sampled level of the reset pin |
| rto_dis_i | input | 1 | High suppresses the reset-pin drive on timeout |
| wdt_rst_o | output | 1 | Internal reset request, one machine cycle long |
| rst_pin_drive_o | output | 1 | Drives the reset pin high after a timeout |

## Verification
On every cycle, the assertions check a set of local rules:
- the watchdog arms only on the edge that takes the key's second byte;
- the count steps by one per machine cycle, and a service write clears it;
- the watchdog leaves the armed state only through a timeout or a qualified external reset;
- the request ends on the next machine-cycle enable;
- the pin drive starts only together with a request.

Other behaviours span thousands of cycles or depend on what was absent, so only the bench scenarios can show them:
- the exact 16384-cycle timeout distance;
- the service restart;
- the rejection of broken or misaddressed key sequences;
- the lasting effect of a qualified external reset;
- the 98-clock pin width.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [7:0] WDT_SFR_ADDR = 8'hA6;
  localparam logic [7:0] WDT_KEY_LO   = 8'h1E;
  localparam logic [7:0] WDT_KEY_HI   = 8'hE1;

  typedef enum logic {
    KEY_IDLE   = 1'b0,
    KEY_PRIMED = 1'b1
  } key_state_t;
endpackage

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
  import wdt_pkg::*;
#(
  parameter logic [7:0] REG_ADDR   = WDT_SFR_ADDR,
  parameter logic [7:0] KEY_FIRST  = WDT_KEY_LO,
  parameter logic [7:0] KEY_SECOND = WDT_KEY_HI
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       flush,
  input  logic       we,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic       hit_o
);
  key_state_t state_q;
  logic       sel;

  assign sel   = we && (addr == REG_ADDR);
  assign hit_o = sel && (state_q == KEY_PRIMED) && (wdata == KEY_SECOND);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      state_q <= KEY_IDLE;
    end else if (sel) begin
      state_q <= (wdata == KEY_FIRST) ? KEY_PRIMED : KEY_IDLE;
    end
  end

  // R4: only a first-key write to the register can prime the sequence
  assert_prime_by_first_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(state_q == KEY_PRIMED) |-> $past(we && addr == REG_ADDR && wdata == KEY_FIRST));
endmodule

// File: rtl/wdt_pin_filter.sv
module wdt_pin_filter #(
  parameter int FILT_MC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic mc_en,
  input  logic pin_i,
  output logic qual_o
);
  localparam int FW = $clog2(FILT_MC + 1);
  logic [FW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst || !pin_i) begin
      run_q <= '0;
    end else if (mc_en && (run_q != FW'(FILT_MC))) begin
      run_q <= run_q + 1'b1;
    end
  end

  assign qual_o = (run_q == FW'(FILT_MC));

  // R9: a qualified reset only appears while the pin is high
  assert_qual_needs_pin_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(qual_o) |-> $past(pin_i));
  assert_qual_drops_R9: assert property (@(posedge clk) disable iff (rst)
    !pin_i |=> !qual_o);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_rst,
  input  logic mc_en,
  input  logic key_hit,
  output logic armed_o,
  output logic ovf_o,
  output logic req_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             armed_q;
  logic             req_q;
  logic [CNT_W-1:0] cnt_q;

  assign ovf_o   = armed_q && mc_en && !key_hit && !ext_rst && (cnt_q == CNT_MAX);
  assign armed_o = armed_q;
  assign req_o   = req_q;

  always_ff @(posedge clk) begin
    if (rst || ext_rst) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      req_q   <= 1'b0;
    end else begin
      if (mc_en) req_q <= 1'b0;
      if (key_hit) begin
        armed_q <= 1'b1;
        cnt_q   <= '0;
      end else if (armed_q && mc_en) begin
        if (cnt_q == CNT_MAX) begin
          armed_q <= 1'b0;
          cnt_q   <= '0;
          req_q   <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
    armed_q && mc_en && !key_hit && !ext_rst && (cnt_q != CNT_MAX)
      |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
  assert_service_clears_R3: assert property (@(posedge clk) disable iff (rst)
    key_hit && !ext_rst |=> armed_q && (cnt_q == '0));
  assert_disarm_only_by_reset_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(armed_q) |-> $past(ext_rst || ovf_o));
  assert_req_ends_R6: assert property (@(posedge clk) disable iff (rst)
    req_q && mc_en |=> !req_q);
  assert_req_holds_R6: assert property (@(posedge clk) disable iff (rst)
    req_q && !mc_en && !ext_rst |=> req_q);
  assert_ext_idles_R9: assert property (@(posedge clk) disable iff (rst)
    ext_rst |=> !armed_q && !req_q);
  assert_no_req_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !armed_q |=> !$rose(req_q));
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int PULSE_LEN = 98
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic dis,
  output logic pin_o
);
  localparam int PW = $clog2(PULSE_LEN + 1);
  logic [PW-1:0] left_q;
  logic          pin_q;
  logic          fire;

  assign fire  = start && !dis;
  assign pin_o = pin_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
      pin_q  <= 1'b0;
    end else begin
      pin_q <= fire || (left_q > PW'(1));
      if (fire) left_q <= PW'(PULSE_LEN);
      else if (left_q != '0) left_q <= left_q - 1'b1;
    end
  end

  assert_pin_starts_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(pin_o) |-> $past(start && !dis));
  assert_pin_suppressed_R8: assert property (@(posedge clk) disable iff (rst)
    start && dis && !pin_o |=> !pin_o);
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_pkg::*;
#(
  parameter int         CNT_W      = 14,
  parameter int         PULSE_LEN  = 98,
  parameter int         FILT_MC    = 2,
  parameter logic [7:0] REG_ADDR   = WDT_SFR_ADDR,
  parameter logic [7:0] KEY_FIRST  = WDT_KEY_LO,
  parameter logic [7:0] KEY_SECOND = WDT_KEY_HI
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mc_en,
  input  logic       sfr_we,
  input  logic [7:0] sfr_addr,
  input  logic [7:0] sfr_wdata,
  input  logic       rst_pin_i,
  input  logic       rto_dis_i,
  output logic       wdt_rst_o,
  output logic       rst_pin_drive_o
);
  logic ext_rst;
  logic key_hit;
  logic armed;
  logic ovf;

  wdt_pin_filter #(.FILT_MC(FILT_MC)) u_filter (
    .clk(clk), .rst(rst), .mc_en(mc_en), .pin_i(rst_pin_i), .qual_o(ext_rst)
  );

  wdt_key_seq #(.REG_ADDR(REG_ADDR), .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)) u_keys (
    .clk(clk), .rst(rst), .flush(ext_rst || ovf), .we(sfr_we),
    .addr(sfr_addr), .wdata(sfr_wdata), .hit_o(key_hit)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .ext_rst(ext_rst), .mc_en(mc_en), .key_hit(key_hit),
    .armed_o(armed), .ovf_o(ovf), .req_o(wdt_rst_o)
  );

  wdt_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst(rst), .start(ovf), .dis(rto_dis_i), .pin_o(rst_pin_drive_o)
  );

  assert_arm_on_key_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(armed) |-> $past(sfr_we && sfr_addr == REG_ADDR && sfr_wdata == KEY_SECOND));
  assert_pin_with_req_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_pin_drive_o) |-> $rose(wdt_rst_o));
  assert_pin_off_when_disabled_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(wdt_rst_o) && $past(rto_dis_i) |-> !rst_pin_drive_o);
endmodule

// File: tb/wdt_guard_test.sv
module wdt_guard_test;
  localparam int TMO = 16384;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mc_en = 1'b0;
  logic       sfr_we = 1'b0;
  logic [7:0] sfr_addr = 8'h00;
  logic [7:0] sfr_wdata = 8'h00;
  logic       rst_pin_i = 1'b0;
  logic       rto_dis_i = 1'b0;
  logic       wdt_rst_o;
  logic       rst_pin_drive_o;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  int mc_div = 1;
  int ph = 0;
  int n_rise = 0;
  int n_prise = 0;

  typedef struct { int rise; int rlen; int plen; } exp_t;
  exp_t sb[$];
  exp_t cur;
  int   rcnt = 0, pcnt = 0;
  logic req_prev = 1'b0, pin_prev = 1'b0;

  always #4 clk = ~clk;

  wdt_guard uut (
    .clk(clk), .rst(rst), .mc_en(mc_en), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .rst_pin_i(rst_pin_i), .rto_dis_i(rto_dis_i),
    .wdt_rst_o(wdt_rst_o), .rst_pin_drive_o(rst_pin_drive_o)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    ph = (ph + 1 >= mc_div) ? 0 : ph + 1;
    mc_en <= (ph == 0);
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // monitor: pops expected timeout events and compares them against the outputs
  always @(negedge clk) begin
    if (!rst) begin
      if (wdt_rst_o && !req_prev) begin
        n_rise++;
        rcnt = 0;
        if (sb.size() == 0) begin
          chk("R10 unexpected request", 1, 0);
          cur = '{-1, 0, 0};
        end else begin
          cur = sb.pop_front();
          if (cur.rise >= 0) chk("R2/R3 request cycle", cyc, cur.rise);
          chk("R7/R8 pin level at request", int'(rst_pin_drive_o), int'(cur.plen != 0));
        end
      end
      if (wdt_rst_o) rcnt++;
      if (!wdt_rst_o && req_prev) chk("R6 request length", rcnt, cur.rlen);
      if (rst_pin_drive_o && !pin_prev) begin n_prise++; pcnt = 0; end
      if (rst_pin_drive_o) pcnt++;
      if (!rst_pin_drive_o && pin_prev) chk("R7 pin length", pcnt, cur.plen);
    end
    req_prev = wdt_rst_o;
    pin_prev = rst_pin_drive_o;
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d, output int edge_cyc);
    sfr_we = 1'b1; sfr_addr = a; sfr_wdata = d;
    @(negedge clk);
    edge_cyc = cyc;
    sfr_we = 1'b0;
  endtask

  task automatic arm(output int e2);
    int e1;
    wr(8'hA6, 8'h1E, e1);
    wr(8'hA6, 8'hE1, e2);
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic quiet_window(input string tag);
    int r0, p0;
    r0 = n_rise; p0 = n_prise;
    repeat (TMO + 600) @(negedge clk);
    chk({tag, " no request"}, n_rise - r0, 0);
    chk({tag, " no pin drive"}, n_prise - p0, 0);
  endtask

  initial begin
    int e, e2, r0;
    repeat (5) @(negedge clk);
    chk("R1 request low in reset", int'(wdt_rst_o), 0);
    chk("R1 pin low in reset", int'(rst_pin_drive_o), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 request low after reset", int'(wdt_rst_o), 0);
    chk("R1 pin low after reset", int'(rst_pin_drive_o), 0);

    // R2 basic timeout, with a one-machine-cycle pin glitch that must not count (R9)
    r0 = n_rise;
    arm(e2);
    sb.push_back('{e2 + TMO, 1, 98});
    repeat (100) @(negedge clk);
    rst_pin_i = 1'b1; @(negedge clk); rst_pin_i = 1'b0;
    wait_until(e2 + TMO + 150);
    chk("R2/R9 one timeout after short pin glitch", n_rise - r0, 1);

    // R4 ignored writes, R10 idle after timeout
    wr(8'hA6, 8'hE1, e);
    wr(8'hA6, 8'h1E, e); wr(8'hA6, 8'h55, e); wr(8'hA6, 8'hE1, e);
    wr(8'hA5, 8'h1E, e); wr(8'hA5, 8'hE1, e);
    quiet_window("R4/R10");

    // R3 service restarts count
    arm(e2);
    repeat (10000) @(negedge clk);
    arm(e2);
    sb.push_back('{e2 + TMO, 1, 98});
    wait_until(e2 + TMO + 150);
    chk("R3 exactly one timeout after service", sb.size(), 0);

    // R5 stray writes cannot stop it, R8 pin suppressed
    rto_dis_i = 1'b1;
    r0 = n_rise;
    arm(e2);
    sb.push_back('{e2 + TMO, 1, 0});
    repeat (20) @(negedge clk);
    wr(8'hA6, 8'h00, e); wr(8'hA6, 8'h1E, e); wr(8'hA6, 8'h00, e); wr(8'hA6, 8'hFF, e);
    wait_until(e2 + TMO + 150);
    chk("R5 timeout despite stray writes", n_rise - r0, 1);
    chk("R8 pin stays low with disable", int'(rst_pin_drive_o), 0);
    rto_dis_i = 1'b0;

    // R9 qualified external reset disarms
    arm(e2);
    repeat (50) @(negedge clk);
    rst_pin_i = 1'b1; repeat (3) @(negedge clk); rst_pin_i = 1'b0;
    quiet_window("R9");

    // R6 request spans one machine cycle of three clocks
    mc_div = 3;
    repeat (6) @(negedge clk);
    r0 = n_rise;
    arm(e2);
    sb.push_back('{-1, 3, 98});
    wait_until(e2 + 3 * TMO + 300);
    chk("R6 timeout at slow machine cycle", n_rise - r0, 1);

    chk("R2 scoreboard drained", sb.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule